// File: doc/BRIEF.md
# Cascadable 32-Input Interrupt Aggregator

This block gathers thirty-two interrupt request lines into a single pending register and reports them on one wired interrupt line to a parent controller. The parent may itself be another copy of this block, so trees of aggregators can be built. Every request line passes through a two-stage synchronizer. It is then sensed either as level-high or as rising-edge. The choice is made once for all lines by a single control bit.

Software reaches three registers over a simple synchronous bus: pending, mask and control. Pending bits are acknowledged by writing zero to them; bits written with one are left alone. The mask only gates the output. A masked source still records into the pending register, so unmasking it later raises the output if the bit is still set. A second control bit is kept for software and read back, but it has no effect on the wired output.

Top module: `intagg_top`

## Requirements
- R1: After reset the pending register reads 0x00000000, the mask register reads 0xFFFFFFFF, the control register reads 0x00000000 and `irq_out` is 0.
- R2: A read returns its data on `bus_rdata` one cycle after the address is presented. The pending register is at byte offset 0x00, the mask at 0x10 and the control at 0x28.
- R3: With control bit 3 at 0 (level mode), pending bit i is set on every cycle that synchronized input i is high. It stays set after the input drops, until it is acknowledged.
- R4: With control bit 3 at 1 (edge mode), only a 0-to-1 transition of synchronized input i sets pending bit i. A line held high sets the bit only once, and an acknowledge while the line stays high clears it.
- R5: A write to offset 0x00 clears each pending bit whose write-data bit is 0 and leaves each bit whose write-data bit is 1 unchanged.
- R6: If a set condition for bit i and an acknowledge of bit i act on the same clock edge, the bit ends up set.
- R7: Mask bit i at 1 keeps pending bit i from driving `irq_out` but does not stop it from being recorded; mask bit i at 0 lets it through.
- R8: `irq_out` is a register that, one cycle later, equals the OR over i of (pending[i] AND NOT mask[i]).
- R9: Control bit 5 is stored and read back and does not change `irq_out`. Control bits other than 3 and 5 read as 0.
- R10: Reads from any offset other than 0x00, 0x10 and 0x28 return 0. Writes to those offsets change no register.
- R11: A write to offset 0x10 replaces all thirty-two mask bits with the write data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Interrupt request lines, bit i is source i |
| bus_addr | input | 6 | Register byte offset |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, for the address of the previous cycle |
| irq_out | output | 1 | Wired interrupt toward the parent controller |

## Verification
A request line that changes before clock edge n reaches the second synchronizer stage at edge n+1. It sets its pending bit at edge n+2 and moves `irq_out` at edge n+3. Register writes take effect at the edge that samples them, and read data appears at the edge after the address. The bench's behavioural model keeps the same sample points: it shifts each input through a two-entry queue, updates its register copies at every rising edge from inputs driven on the falling edge, and compares `irq_out` and `bus_rdata` on the next falling edge. The directed reads are placed so that the acknowledge write and a new edge reach the same rising edge for the R6 collision.

// File: rtl/intagg_pkg.sv
package intagg_pkg;
  typedef enum logic {SENSE_LEVEL = 1'b0, SENSE_RISE = 1'b1} sense_e;

  localparam logic [5:0] OFF_PEND = 6'h00;
  localparam logic [5:0] OFF_MASK = 6'h10;
  localparam logic [5:0] OFF_CTRL = 6'h28;

  localparam int CTRL_RISE_BIT = 3;
  localparam int CTRL_MSG_BIT  = 5;
endpackage

// File: rtl/intagg_sync.sv
module intagg_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1   <= '0;
      sync_out <= '0;
    end else begin
      stage1   <= async_in;
      sync_out <= stage1;
    end
  end
endmodule

// File: rtl/intagg_pending.sv
module intagg_pending
  import intagg_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  sense_e       sense,
  input  logic [W-1:0] req,
  input  logic         ack_we,
  input  logic [W-1:0] ack_data,
  output logic [W-1:0] pend
);
  logic [W-1:0] req_prev;
  logic [W-1:0] set_vec;

  function automatic logic [W-1:0] sense_hits(sense_e s, logic [W-1:0] now,
                                               logic [W-1:0] prev);
    return (s == SENSE_RISE) ? (now & ~prev) : now;
  endfunction

  function automatic logic [W-1:0] apply_ack(logic [W-1:0] cur, logic we,
                                              logic [W-1:0] keep);
    return we ? (cur & keep) : cur;
  endfunction

  assign set_vec = sense_hits(sense, req, req_prev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_prev <= '0;
      pend     <= '0;
    end else begin
      req_prev <= req;
      pend     <= apply_ack(pend, ack_we, ack_data) | set_vec;
    end
  end

  // R6: a set condition always survives the edge, acknowledge or not
  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & $past(set_vec)) == $past(set_vec)));

  // R3, R4: with no set and no acknowledge, pending bits hold
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_we && set_vec == '0) |=> $stable(pend));

  // R5: an acknowledge with nothing new clears exactly the zero bits
  p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_we && set_vec == '0) |=> (pend == ($past(pend) & $past(ack_data))));
endmodule

// File: rtl/intagg_top.sv
module intagg_top
  import intagg_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_out
);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(OFF_PEND);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFF_MASK);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);

  logic [NUM_SRC-1:0] req_sync;
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] mask_q;
  logic               rise_q;
  logic               msg_q;
  logic               pend_wr;
  logic               mask_wr;
  logic               ctrl_wr;

  function automatic logic is_mapped(logic [ADDR_W-1:0] a);
    return (a == A_PEND) || (a == A_MASK) || (a == A_CTRL);
  endfunction

  function automatic logic [DATA_W-1:0] read_mux(logic [ADDR_W-1:0] a,
      logic [NUM_SRC-1:0] p, logic [NUM_SRC-1:0] m, logic r, logic g);
    logic [DATA_W-1:0] v;
    v = '0;
    if (a == A_PEND) v[NUM_SRC-1:0] = p;
    else if (a == A_MASK) v[NUM_SRC-1:0] = m;
    else if (a == A_CTRL) begin
      v[CTRL_RISE_BIT] = r;
      v[CTRL_MSG_BIT]  = g;
    end
    return v;
  endfunction

  assign pend_wr = bus_we && (bus_addr == A_PEND);
  assign mask_wr = bus_we && (bus_addr == A_MASK);
  assign ctrl_wr = bus_we && (bus_addr == A_CTRL);

  intagg_sync #(.W(NUM_SRC)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (irq_in),
    .sync_out (req_sync)
  );

  intagg_pending #(.W(NUM_SRC)) u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .sense    (sense_e'(rise_q)),
    .req      (req_sync),
    .ack_we   (pend_wr),
    .ack_data (bus_wdata[NUM_SRC-1:0]),
    .pend     (pend)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q    <= '1;
      rise_q    <= 1'b0;
      msg_q     <= 1'b0;
      bus_rdata <= '0;
      irq_out   <= 1'b0;
    end else begin
      if (mask_wr) mask_q <= bus_wdata[NUM_SRC-1:0];
      if (ctrl_wr) begin
        rise_q <= bus_wdata[CTRL_RISE_BIT];
        msg_q  <= bus_wdata[CTRL_MSG_BIT];
      end
      bus_rdata <= read_mux(bus_addr, pend, mask_q, rise_q, msg_q);
      irq_out   <= |(pend & ~mask_q);
    end
  end

  // R8: the output never rises without some pending bit a cycle before
  p_irq_needs_pend_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> ($past(pend) != '0));

  // R7: a fully masked controller stays quiet
  p_full_mask_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |=> !irq_out);

  // R10: unmapped offsets read zero
  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !is_mapped(bus_addr) |=> (bus_rdata == '0));

  // R11: a mask write lands whole
  p_mask_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> (mask_q == $past(bus_wdata[NUM_SRC-1:0])));
endmodule

// File: tb/test_intagg_top.sv
module test_intagg_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = '0;
  logic [5:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  intagg_top i_intagg_top (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out)
  );

  // behavioural reference model
  logic [31:0] m_q[$];
  logic [31:0] m_prev = '0, m_pend = '0, m_mask = '1, m_ctrl = '0;
  logic [31:0] e_rdata = '0;
  logic        e_irq = 1'b0;

  function automatic logic [31:0] m_read(logic [5:0] a);
    case (a)
      6'h00: return m_pend;
      6'h10: return m_mask;
      6'h28: return m_ctrl;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    m_q.push_back('0);
    m_q.push_back('0);
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_q.delete(); m_q.push_back('0); m_q.push_back('0);
      m_prev = '0; m_pend = '0; m_mask = '1; m_ctrl = '0;
      e_rdata = '0; e_irq = 1'b0;
    end else begin
      logic [31:0] now, hits;
      e_rdata = m_read(bus_addr);
      e_irq   = (m_pend & ~m_mask) != 0;
      now  = m_q[0];
      hits = m_ctrl[3] ? (now & ~m_prev) : now;
      m_prev = now;
      if (bus_we && bus_addr == 6'h00) m_pend = m_pend & bus_wdata;
      m_pend = m_pend | hits;
      if (bus_we && bus_addr == 6'h10) m_mask = bus_wdata;
      if (bus_we && bus_addr == 6'h28) m_ctrl = bus_wdata & 32'h28;
      void'(m_q.pop_front());
      m_q.push_back(irq_in);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(irq_out === e_irq, "R8 irq_out model", {31'b0, irq_out}, {31'b0, e_irq});
      check(bus_rdata === e_rdata, "R2 rdata model", bus_rdata, e_rdata);
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    check(bus_rdata === exp, tag, bus_rdata, exp);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    rd(6'h00, 32'h0, "R1 pending reset");
    rd(6'h10, 32'hFFFFFFFF, "R1 mask reset");
    rd(6'h28, 32'h0, "R1 control reset");
    check(irq_out === 1'b0, "R1 irq_out reset", {31'b0, irq_out}, 32'h0);

    // R11 mask write, R3 level sensing
    wr(6'h10, 32'h0000_0000);
    rd(6'h10, 32'h0, "R11 mask cleared");
    irq_in[3] = 1'b1;
    idle(4);
    rd(6'h00, 32'h8, "R3 level sets pending");
    check(irq_out === 1'b1, "R8 irq_out on pending", {31'b0, irq_out}, 32'h1);
    wr(6'h00, 32'h0);
    rd(6'h00, 32'h8, "R6 level high beats ack");
    irq_in[3] = 1'b0;
    idle(3);
    rd(6'h00, 32'h8, "R3 level bit held after drop");
    wr(6'h00, ~32'h8 | 32'h10);
    rd(6'h00, 32'h0, "R5 zero clears bit");
    idle(2);
    check(irq_out === 1'b0, "R8 irq_out after clear", {31'b0, irq_out}, 32'h0);

    // R5 ones keep bits
    irq_in[1] = 1'b1; irq_in[2] = 1'b1;
    @(negedge clk); irq_in[1] = 1'b0; irq_in[2] = 1'b0;
    idle(3);
    wr(6'h00, 32'h4);
    rd(6'h00, 32'h4, "R5 one keeps bit");
    wr(6'h00, 32'h0);

    // R7 masked source still records
    wr(6'h10, 32'h1);
    irq_in[0] = 1'b1;
    @(negedge clk); irq_in[0] = 1'b0;
    idle(4);
    rd(6'h00, 32'h1, "R7 masked source recorded");
    check(irq_out === 1'b0, "R7 masked keeps output low", {31'b0, irq_out}, 32'h0);
    wr(6'h10, 32'h0);
    idle(1);
    check(irq_out === 1'b1, "R7 unmask raises output", {31'b0, irq_out}, 32'h1);
    wr(6'h00, 32'h0);

    // R4 edge mode
    wr(6'h28, 32'h8);
    irq_in[7] = 1'b1;
    idle(4);
    rd(6'h00, 32'h80, "R4 rising edge sets");
    wr(6'h00, 32'h0);
    idle(3);
    rd(6'h00, 32'h0, "R4 held line does not re-set");
    irq_in[7] = 1'b0;
    idle(3);
    irq_in[7] = 1'b1;
    idle(4);
    rd(6'h00, 32'h80, "R4 second edge sets");
    irq_in[7] = 1'b0;
    wr(6'h00, 32'h0);

    // R6 edge and acknowledge on the same edge
    irq_in[12] = 1'b1;
    @(negedge clk); irq_in[12] = 1'b0;
    idle(4);
    irq_in[12] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); bus_addr = 6'h00; bus_we = 1'b1; bus_wdata = 32'h0;
    @(negedge clk); bus_we = 1'b0;
    rd(6'h00, 32'h1000, "R6 edge beats ack");
    irq_in[12] = 1'b0;
    wr(6'h00, 32'h0);

    // R9 control bit 5 stored, inert
    wr(6'h28, 32'hFFFF_FFFF);
    rd(6'h28, 32'h28, "R9 control readback");
    irq_in[20] = 1'b1;
    idle(4);
    check(irq_out === 1'b1, "R9 msg bit leaves irq_out", {31'b0, irq_out}, 32'h1);
    irq_in[20] = 1'b0;
    wr(6'h00, 32'h0);

    // R10 unmapped offsets
    wr(6'h04, 32'hFFFF_FFFF);
    wr(6'h14, 32'h0);
    rd(6'h04, 32'h0, "R10 unmapped read zero");
    rd(6'h3C, 32'h0, "R10 unmapped read zero high");
    rd(6'h10, 32'h0, "R10 mask untouched");
    rd(6'h00, 32'h0, "R10 pending untouched");
    idle(2);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule